// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block holds the per-pin routing table of an interrupt router, together with a small identification and version register set. Software never addresses a table entry directly. It first writes an index into a select register, then reads or writes the chosen 32-bit register through a single data window. Each table entry is 64 bits wide, so it takes two select values: one for the lower half and one for the upper half.

The whole table is driven out in parallel for the delivery logic. That logic owns two status bits in every entry, the remote-IRR flag and the delivery-status flag, and changes them through per-pin set and clear strobes. A software write to the lower half cannot alter either flag. If the write leaves a level-triggered, unmasked entry idle while its input line is high, the block latches remote-IRR and sends a one-cycle deliver request for that pin. The delivery logic then acts on that request.

Top module: `irr_redir_regs`

## Requirements
- R1: The bus address is 8 bits. Offset 0x00 is the select register, which reads back its last written 8 bits with bits 31:8 zero. Offset 0x10 is the data window. Reads of any other offset return zero and writes to them change nothing. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: Select value 0x01 is the version register. It reads as (NPINS-1) in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Writes to it change nothing.
- R3: Select value 0x00 is the identification register, whose 4-bit ID is written from and read in bits 27:24. Select value 0x02 reads the same ID and ignores writes. Select values 0x03 to 0x0F read zero and ignore writes.
- R4: For a select value S of 0x10 or more, the entry index is (S-0x10)>>1. An odd S reaches bits 63:32 of the entry and an even S reaches bits 31:0.
- R5: An entry index of NPINS or more reads zero and ignores writes.
- R6: An upper-half write replaces bits 63:32 of the entry, where the destination ID sits in bits 63:56, and leaves bits 31:0 unchanged.
- R7: A lower-half write stores the written bits 31:0. Delivery status (bit 12) is forced to 0, and remote-IRR (bit 14) keeps its value. The other lower fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger mode 15 (1 = level) and mask 16.
- R8: After reset, every entry equals 0x0000_0000_0001_0000 (only the mask bit set), the ID and select registers are zero, `bus_rdata` is zero and no deliver request is raised.
- R9: If, after a lower-half write, the entry is level-triggered and unmasked, remote-IRR is 0, and `line_level` for that pin is 1, then remote-IRR becomes 1 and `deliver` for that pin pulses high for exactly one cycle. Both changes appear in the cycle after the write.
- R10: `irr_set` and `irr_clr` set and clear remote-IRR one cycle later, and `stat_set` and `stat_clr` do the same for delivery status. When set and clear come together, clear wins. A lower-half write in the same cycle overrides any delivery-status update. A remote-IRR update in the same cycle as a lower-half write is applied before the R9 test.
- R11: `entries` carries entry i on bits [64*i+63 : 64*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Low byte of the bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| line_level | input | NPINS | Current level of each interrupt input line |
| irr_set | input | NPINS | Per-pin remote-IRR set strobe |
| irr_clr | input | NPINS | Per-pin remote-IRR clear strobe (end of interrupt) |
| stat_set | input | NPINS | Per-pin delivery-status set strobe |
| stat_clr | input | NPINS | Per-pin delivery-status clear strobe |
| entries | output | 64*NPINS | All table entries, flattened |
| deliver | output | NPINS | One-cycle deliver request per pin |

## Verification
The bench targets the places where the two-level addressing can go wrong:
- The first and last pins are checked. A design that dropped the shift in the index formula, or swapped the odd and even halves, would put data in the wrong entry or the wrong half.
- Index 24 is written and read. A design that accepted it would read back a stale value instead of zero.
- Lower-half writes are made with remote-IRR set and with delivery status set. A design that let software through would clear the latched IRR or leave the busy flag raised.
- The re-check is driven with the line high and low, with the entry masked and unmasked, with IRR already latched, and with an end-of-interrupt clear in the same cycle. A wrong condition either misses a deliver pulse or sends a duplicate one.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int SEL_W      = 8;
    localparam int IDX_W      = 7;
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] SEL_IDENT  = 8'h00;
    localparam logic [7:0] SEL_VERS   = 8'h01;
    localparam logic [7:0] SEL_ARBIT  = 8'h02;
    localparam logic [7:0] SEL_TABLE0 = 8'h10;

    // bit positions inside one 64-bit entry
    localparam int B_STAT = 12;
    localparam int B_IRR  = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_IDENT,
        WK_VERS,
        WK_ARBIT,
        WK_TABLE
    } win_kind_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [3:0]       id;
        logic [31:0]      rdata;
    } top_state_t;

    typedef struct packed {
        logic [63:0] ent;
        logic        dlv;
    } entry_state_t;

endpackage

// File: rtl/irr_sel_decode.sv
module irr_sel_decode
    import irr_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic [SEL_W-1:0] sel,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);
    logic [SEL_W-1:0] offset;

    always_comb begin
        offset = sel - SEL_TABLE0;
        idx    = offset[SEL_W-1:1];
        upper  = sel[0];
        if (sel == SEL_IDENT)
            kind = WK_IDENT;
        else if (sel == SEL_VERS)
            kind = WK_VERS;
        else if (sel == SEL_ARBIT)
            kind = WK_ARBIT;
        else if (sel >= SEL_TABLE0 && int'(idx) < NPINS)
            kind = WK_TABLE;
        else
            kind = WK_NONE;
    end
endmodule

// File: rtl/irr_entry.sv
module irr_entry
    import irr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        line,
    input  logic        irr_set,
    input  logic        irr_clr,
    input  logic        stat_set,
    input  logic        stat_clr,
    output logic [63:0] entry_o,
    output logic        deliver_o
);
    entry_state_t st_d, st_q;
    logic irr_hw;
    logic stat_hw;

    always_comb begin
        st_d     = st_q;
        st_d.dlv = 1'b0;

        // hardware-owned flags: clear beats set
        irr_hw  = irr_clr  ? 1'b0 : (irr_set  ? 1'b1 : st_q.ent[B_IRR]);
        stat_hw = stat_clr ? 1'b0 : (stat_set ? 1'b1 : st_q.ent[B_STAT]);
        st_d.ent[B_IRR]  = irr_hw;
        st_d.ent[B_STAT] = stat_hw;

        if (wr_hi)
            st_d.ent[63:32] = wdata;

        if (wr_lo) begin
            st_d.ent[31:0]   = wdata;
            st_d.ent[B_STAT] = 1'b0;
            st_d.ent[B_IRR]  = irr_hw;
            if (st_d.ent[B_TRIG] && !st_d.ent[B_MASK] && !irr_hw && line) begin
                st_d.ent[B_IRR] = 1'b1;
                st_d.dlv        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ent <= ENTRY_RESET;
            st_q.dlv <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_o   = st_q.ent;
    assign deliver_o = st_q.dlv;

    assert_lowwr_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !entry_o[B_STAT]);

    assert_lowwr_irr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !irr_set && !irr_clr) |=>
            (entry_o[B_IRR] == $past(entry_o[B_IRR])) || deliver_o);

    assert_deliver_irr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_o |-> entry_o[B_IRR]);

    assert_deliver_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_o |-> (entry_o[B_TRIG] && !entry_o[B_MASK] && $past(wr_lo)));

    assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_clr && !wr_lo) |=> !entry_o[B_IRR]);
endmodule

// File: rtl/irr_read_mux.sv
module irr_read_mux
    import irr_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  win_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic             upper,
    input  logic [3:0]       id,
    input  logic [63:0]      table_i [NPINS],
    output logic [31:0]      value
);
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [63:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (int'(idx) == i)
                picked = table_i[i];
        end
        case (kind)
            WK_IDENT, WK_ARBIT: value = {4'b0, id, 24'b0};
            WK_VERS:            value = {8'b0, MAX_PIN, 8'b0, VERSION};
            WK_TABLE:           value = upper ? picked[63:32] : picked[31:0];
            default:            value = '0;
        endcase
    end
endmodule

// File: rtl/irr_redir_regs.sv
module irr_redir_regs
    import irr_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    line_level,
    input  logic [NPINS-1:0]    irr_set,
    input  logic [NPINS-1:0]    irr_clr,
    input  logic [NPINS-1:0]    stat_set,
    input  logic [NPINS-1:0]    stat_clr,
    output logic [64*NPINS-1:0] entries,
    output logic [NPINS-1:0]    deliver
);
    top_state_t       st_d, st_q;
    win_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             upper;
    logic [31:0]      win_val;
    logic [63:0]      tbl [NPINS];
    logic             hit_sel;
    logic             hit_win;
    logic             tbl_wr;

    assign hit_sel = (bus_addr == OFS_SELECT);
    assign hit_win = (bus_addr == OFS_WINDOW);
    assign tbl_wr  = bus_wr && hit_win && (kind == WK_TABLE);

    irr_sel_decode #(.NPINS(NPINS)) u_dec (
        .sel   (st_q.sel),
        .kind  (kind),
        .idx   (idx),
        .upper (upper)
    );

    irr_read_mux #(.NPINS(NPINS), .VERSION(VERSION)) u_mux (
        .kind    (kind),
        .idx     (idx),
        .upper   (upper),
        .id      (st_q.id),
        .table_i (tbl),
        .value   (win_val)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic pick;
        assign pick = tbl_wr && (int'(idx) == p);
        irr_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (pick && !upper),
            .wr_hi     (pick && upper),
            .wdata     (bus_wdata),
            .line      (line_level[p]),
            .irr_set   (irr_set[p]),
            .irr_clr   (irr_clr[p]),
            .stat_set  (stat_set[p]),
            .stat_clr  (stat_clr[p]),
            .entry_o   (tbl[p]),
            .deliver_o (deliver[p])
        );
        assign entries[64*p +: 64] = tbl[p];
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && hit_sel)
            st_d.sel = bus_wdata[SEL_W-1:0];
        if (bus_wr && hit_win && kind == WK_IDENT)
            st_d.id = bus_wdata[27:24];
        if (bus_rd) begin
            if (hit_sel)
                st_d.rdata = {{(32-SEL_W){1'b0}}, st_q.sel};
            else if (hit_win)
                st_d.rdata = win_val;
            else
                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    assert_other_offset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_sel && !hit_win) |=> (bus_rdata == 32'h0));

    assert_version_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_win && st_q.sel == SEL_VERS) |=>
            (bus_rdata == {8'b0, 8'(NPINS - 1), 8'b0, VERSION}));

    assert_id_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit_win && st_q.sel == SEL_IDENT) |=> $stable(st_q.id));

    assert_range_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_win && st_q.sel >= SEL_TABLE0 && kind == WK_NONE) |=>
            (bus_rdata == 32'h0));
endmodule

// File: tb/test_irr_redir_regs.sv
module test_irr_redir_regs;
    localparam int N = 24;
    localparam logic [7:0] VER = 8'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    b_addr = '0;
    logic          b_wr = 1'b0;
    logic          b_rd = 1'b0;
    logic [31:0]   b_wdata = '0;
    logic [31:0]   b_rdata;
    logic [N-1:0]  line = '0;
    logic [N-1:0]  iset = '0;
    logic [N-1:0]  iclr = '0;
    logic [N-1:0]  sset = '0;
    logic [N-1:0]  sclr = '0;
    logic [64*N-1:0] ents;
    logic [N-1:0]  dlv;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [63:0] m_ent [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [31:0] m_rd;
    logic [N-1:0] m_dlv;
    // next state
    logic [63:0] n_ent [N];
    logic [7:0]  n_sel;
    logic [3:0]  n_id;
    logic [31:0] n_rd;
    logic [N-1:0] n_dlv;

    always #10 clk = ~clk;

    irr_redir_regs #(.NPINS(N), .VERSION(VER)) i_irr_redir_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .line_level(line),
        .irr_set(iset), .irr_clr(iclr), .stat_set(sset), .stat_clr(sclr),
        .entries(ents), .deliver(dlv)
    );

    function automatic logic [31:0] m_window();
        int ix;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'b0, m_id, 24'b0};
        if (m_sel == 8'h01) return {8'b0, 8'(N - 1), 8'b0, VER};
        if (m_sel < 8'h10) return 32'h0;
        ix = (int'(m_sel) - 16) / 2;
        if (ix >= N) return 32'h0;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = '0; m_id = '0; m_rd = '0; m_dlv = '0;
    endtask

    task automatic model_next();
        logic irr;
        int ix;
        for (int i = 0; i < N; i++) begin
            n_ent[i] = m_ent[i];
            if (iclr[i]) n_ent[i][14] = 1'b0;
            else if (iset[i]) n_ent[i][14] = 1'b1;
            if (sclr[i]) n_ent[i][12] = 1'b0;
            else if (sset[i]) n_ent[i][12] = 1'b1;
        end
        n_sel = m_sel; n_id = m_id; n_rd = m_rd; n_dlv = '0;
        if (b_rd)
            n_rd = (b_addr == 8'h00) ? {24'b0, m_sel} :
                   (b_addr == 8'h10) ? m_window() : 32'h0;
        if (b_wr && b_addr == 8'h00) n_sel = b_wdata[7:0];
        if (b_wr && b_addr == 8'h10) begin
            if (m_sel == 8'h00) n_id = b_wdata[27:24];
            else if (m_sel >= 8'h10) begin
                ix = (int'(m_sel) - 16) / 2;
                if (ix < N) begin
                    if (m_sel[0]) n_ent[ix][63:32] = b_wdata;
                    else begin
                        irr = n_ent[ix][14];
                        n_ent[ix][31:0] = b_wdata;
                        n_ent[ix][12] = 1'b0;
                        n_ent[ix][14] = irr;
                        if (b_wdata[15] && !b_wdata[16] && !irr && line[ix]) begin
                            n_ent[ix][14] = 1'b1;
                            n_dlv[ix] = 1'b1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [64*N-1:0] exp_flat;
        for (int i = 0; i < N; i++) exp_flat[64*i +: 64] = m_ent[i];
        checks++;
        if (b_rdata !== m_rd) begin
            fails++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", tag, b_rdata, m_rd);
        end
        checks++;
        if (ents !== exp_flat) begin
            fails++;
            for (int i = 0; i < N; i++)
                if (ents[64*i +: 64] !== m_ent[i])
                    $display("FAIL %s R11 entry %0d actual=%h expected=%h",
                             tag, i, ents[64*i +: 64], m_ent[i]);
        end
        checks++;
        if (dlv !== m_dlv) begin
            fails++;
            $display("FAIL %s R9 deliver actual=%h expected=%h", tag, dlv, m_dlv);
        end
    endtask

    // one clock: model advances with the DUT, compare at the falling edge
    task automatic cyc(input string tag);
        model_next();
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) m_ent[i] = n_ent[i];
        m_sel = n_sel; m_id = n_id; m_rd = n_rd; m_dlv = n_dlv;
        @(negedge clk);
        compare(tag);
        b_wr = 1'b0; b_rd = 1'b0;
        iset = '0; iclr = '0; sset = '0; sclr = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        cyc(tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        b_addr = a; b_rd = 1'b1;
        cyc(tag);
    endtask

    task automatic win_wr(input logic [7:0] s, input logic [31:0] d, input string tag);
        wr(8'h00, {24'b0, s}, tag);
        wr(8'h10, d, tag);
        rd(8'h10, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R8 reset");
        rd(8'h00, "R8 select reset");
        rd(8'h10, "R8 id reset");
        wr(8'h00, 32'h0000_0040, "R8");
        rd(8'h10, "R8 entry 24 low");
        for (int p = 0; p < N; p += 11) begin
            wr(8'h00, 32'(8'h10 + 2*p), "R8");
            rd(8'h10, "R8 entry mask reset");
        end

        // version and id
        wr(8'h00, 32'h1, "R2");
        rd(8'h10, "R2 version");
        wr(8'h10, 32'hFFFF_FFFF, "R2 write ignored");
        rd(8'h10, "R2 version after write");
        win_wr(8'h00, 32'hA5FF_FFFF, "R3 id write");
        win_wr(8'h02, 32'h0F00_0000, "R3 arb ignore");
        wr(8'h00, 32'h0, "R3");
        rd(8'h10, "R3 id unchanged");
        win_wr(8'h05, 32'h1234_5678, "R3 reserved select");

        // offset decode
        wr(8'h00, 32'hFFFF_FF37, "R1 select write");
        rd(8'h00, "R1 select readback");
        wr(8'h04, 32'hDEAD_BEEF, "R1 other offset write");
        rd(8'h04, "R1 other offset read");
        rd(8'h20, "R1 other offset read");
        rd(8'h00, "R1 select unchanged");

        // table halves and indexing
        win_wr(8'h10, 32'h0000_0031, "R4 pin0 low");
        win_wr(8'h11, 32'hAB00_0000, "R6 pin0 high");
        win_wr(8'h1E, 32'h0000_0142, "R4 pin7 low");
        win_wr(8'h1F, 32'h5500_00FF, "R6 pin7 high");
        win_wr(8'h3E, 32'h0000_A3C9, "R4 pin23 low");
        win_wr(8'h3F, 32'hF000_0001, "R6 pin23 high");
        win_wr(8'h10, 32'h0001_0031, "R6 low keeps high");
        rd(8'h10, "R4 pin0 low again");

        // out of range
        win_wr(8'h40, 32'h1111_1111, "R5 index 24");
        win_wr(8'h41, 32'h2222_2222, "R5 index 24 high");
        win_wr(8'hFF, 32'h3333_3333, "R5 index 119");

        // hardware flags
        iset[3] = 1'b1; cyc("R10 irr set");
        sset[3] = 1'b1; cyc("R10 stat set");
        win_wr(8'h16, 32'h0000_5020, "R7 low write keeps irr clears stat");
        iset[5] = 1'b1; iclr[5] = 1'b1; sset[5] = 1'b1; sclr[5] = 1'b1;
        cyc("R10 clear wins");
        sset[6] = 1'b1;
        wr(8'h00, 32'h1C, "R10");
        b_addr = 8'h10; b_wdata = 32'h0000_1044; b_wr = 1'b1; sset[6] = 1'b1;
        cyc("R10 write overrides stat");
        iclr[3] = 1'b1; cyc("R10 irr clear");

        // deliver re-check
        line[4] = 1'b1;
        win_wr(8'h18, 32'h0000_8060, "R9 level unmasked deliver");
        win_wr(8'h18, 32'h0000_8061, "R9 irr set no deliver");
        iclr[4] = 1'b1; cyc("R9 eoi");
        win_wr(8'h18, 32'h0001_8062, "R9 masked no deliver");
        win_wr(8'h18, 32'h0000_0063, "R9 edge no deliver");
        win_wr(8'h18, 32'h0000_8064, "R9 deliver again");
        wr(8'h10, 32'h0000_8065, "R9");
        b_wdata = 32'h0000_8066; b_wr = 1'b1; iclr[4] = 1'b1;
        cyc("R9 eoi with write");
        line[4] = 1'b0;
        iclr[4] = 1'b1; cyc("R9");
        win_wr(8'h18, 32'h0000_8067, "R9 line low no deliver");
        line[N-1] = 1'b1;
        win_wr(8'h3E, 32'h0000_80AA, "R9 last pin deliver");
        repeat (3) cyc("R11 idle");

        summary();
    end
endmodule